// File: doc/BRIEF.md
# UART transmit DMA engine

This block moves a block of bytes from a byte-wide memory into a UART transmitter so that software does not have to feed the transmitter itself. Software first sets a start address, a length and an enable bit through a small register interface. It then writes a trigger bit. The engine reads the bytes one after another through a request/grant memory port and hands each byte to the transmit holding register over a valid/ready handshake. One byte can be fetched ahead into a single holding register while the previous byte waits for the transmitter.

When the last byte has been accepted, a sticky completion flag is set. This flag drives an interrupt request whenever the interrupt enable bit is set. If the CPU writes the UART data register directly while a transfer is running, the transfer is aborted and a sticky overwrite flag is set. In that case the remaining-byte counter keeps its value so that software can see how far the transfer got. The bus priority and the interrupt priority fields from the configuration register are driven out to the memory arbiter and to the interrupt controller.

The reset input is asynchronous and active low, and its release must already be synchronized to `clk`.

Top module: `uart_tx_dma`

## Requirements
- R1: When the enable bit (CTRL bit 0) is 0, a trigger starts nothing and `mem_req` and `tx_valid` stay low. Writing CTRL with bit 0 cleared during a transfer stops it without setting either flag.
- R2: A CTRL write with bit 1 = 1 and bit 0 = 1 starts a transfer. A CTRL write with bit 1 = 0 starts nothing, and CTRL bit 1 always reads back as 0.
- R3: The count register (CNT, offset 3) holds N, and exactly N+1 bytes are read and sent. N = 0 sends one byte and N = 255 sends 256 bytes.
- R4: The read address starts at the 16-bit base (BASE_L offset 4, BASE_H offset 5) and increases by one after each granted read. Every new start reloads it from the base.
- R5: A byte passes to the UART only in a cycle where `tx_valid` and `tx_ready` are both high. Bytes leave in address order, and `tx_data` holds steady while `tx_valid` waits for `tx_ready`.
- R6: The completion flag (STAT bit 0) is set in the cycle after the last byte is accepted. `irq` equals this flag ANDed with the interrupt enable bit (CFG bit 0).
- R7: A pulse on `cpu_dreg_wr` during a transfer drops `tx_valid` and `mem_req` in that same cycle. From the next cycle, busy is 0 and the overwrite flag (STAT bit 1) is 1, and the completion flag is not set. The remaining count (LEFT_L offset 6, LEFT_H offset 7) keeps the number of bytes not yet sent. A pulse while idle has no effect.
- R8: Both status flags stay set until software writes STAT with a 0 in that flag's bit position. Writing a 1 leaves the flag as it is.
- R9: STAT bit 2 (busy) reads 1 from the cycle after a start until completion or abort. A trigger written while busy is ignored.
- R10: `mem_pri` shows CFG bits 4:3 alongside each read request, and `irq_pri` shows CFG bits 2:1.
- R11: Offsets are CFG 0, CTRL 1, STAT 2, CNT 3, BASE_L 4, BASE_H 5, LEFT_L 6, LEFT_H 7. The writable registers read back what was written, and everything resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_pri | output | 2 | Bus priority presented with the request |
| mem_gnt | input | 1 | Grant; `mem_rdata` is valid in the grant cycle |
| mem_rdata | input | 8 | Memory read data |
| tx_data | output | 8 | Byte offered to the UART holding register |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Transmitter can accept a byte |
| cpu_dreg_wr | input | 1 | CPU wrote the UART data register directly |
| irq | output | 1 | Completion interrupt request |
| irq_pri | output | 2 | Interrupt priority field |

## Verification
The bench uses the default parameters: a 16-bit address and an 8-bit count. With these defaults a full 256-byte transfer is possible, as is a base near a 256-byte boundary, so the address counter has to carry into its upper byte during a transfer. The bench drives grants and ready with a pseudo-random pattern, which produces runs where the holding register is full and reads stall behind a slow transmitter. It also fires aborts and disables partway through a transfer, and writes re-triggers while a transfer is still running.

// File: rtl/utd_pkg.sv
package utd_pkg;

  localparam int REG_AW = 3;
  localparam int REG_DW = 8;

  typedef enum logic [REG_AW-1:0] {
    RA_CFG    = 3'd0,
    RA_CTRL   = 3'd1,
    RA_STAT   = 3'd2,
    RA_CNT    = 3'd3,
    RA_BASE_L = 3'd4,
    RA_BASE_H = 3'd5,
    RA_LEFT_L = 3'd6,
    RA_LEFT_H = 3'd7
  } reg_addr_e;

  // Packed MSB first: bus_pri is bits 4:3, irq_pri 2:1, irq_en 0
  typedef struct packed {
    logic [1:0] bus_pri;
    logic [1:0] irq_pri;
    logic       irq_en;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/utd_regs.sv
module utd_regs
  import utd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              cpu_dreg_wr,
  input  logic              done_evt,
  input  logic [CNT_W:0]    send_left,
  output cfg_t              cfg,
  output logic              enable,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] base,
  output logic              start,
  output logic              busy,
  output logic              done_flag,
  output logic              ovw_flag
);

  localparam int HI_W = ADDR_W - 8;

  cfg_t              cfg_q, cfg_d;
  logic              en_q, en_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              ovw_q, ovw_d;

  logic wr_cfg, wr_ctrl, wr_stat, wr_cnt, wr_bl, wr_bh;
  logic abort, kill, clr_done, clr_ovw;

  assign wr_cfg  = reg_we && (reg_addr == RA_CFG);
  assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
  assign wr_stat = reg_we && (reg_addr == RA_STAT);
  assign wr_cnt  = reg_we && (reg_addr == RA_CNT);
  assign wr_bl   = reg_we && (reg_addr == RA_BASE_L);
  assign wr_bh   = reg_we && (reg_addr == RA_BASE_H);

  assign start    = wr_ctrl && reg_wdata[1] && reg_wdata[0] && !busy_q;
  assign abort    = busy_q && cpu_dreg_wr;
  assign kill     = busy_q && wr_ctrl && !reg_wdata[0];
  assign clr_done = wr_stat && !reg_wdata[0];
  assign clr_ovw  = wr_stat && !reg_wdata[1];

  // next state
  always_comb begin
    cfg_d  = cfg_q;
    en_d   = en_q;
    cnt_d  = cnt_q;
    base_d = base_q;
    if (wr_cfg)  cfg_d = cfg_t'(reg_wdata[CFG_W-1:0]);
    if (wr_ctrl) en_d  = reg_wdata[0];
    if (wr_cnt)  cnt_d = reg_wdata[CNT_W-1:0];
    if (wr_bl)   base_d[7:0] = reg_wdata;
    if (wr_bh)   base_d[ADDR_W-1:8] = reg_wdata[HI_W-1:0];

    busy_d = busy_q;
    if (start)                         busy_d = 1'b1;
    else if (abort || kill || done_evt) busy_d = 1'b0;

    done_d = (done_q && !clr_done) || done_evt;
    ovw_d  = (ovw_q && !clr_ovw) || abort;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      en_q   <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ovw_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      en_q   <= en_d;
      cnt_q  <= cnt_d;
      base_q <= base_d;
      busy_q <= busy_d;
      done_q <= done_d;
      ovw_q  <= ovw_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CFG:    reg_rdata = REG_DW'(cfg_q);
      RA_CTRL:   reg_rdata = REG_DW'(en_q);
      RA_STAT:   reg_rdata = REG_DW'({busy_q, ovw_q, done_q});
      RA_CNT:    reg_rdata = REG_DW'(cnt_q);
      RA_BASE_L: reg_rdata = base_q[7:0];
      RA_BASE_H: reg_rdata = REG_DW'(base_q >> 8);
      RA_LEFT_L: reg_rdata = REG_DW'(send_left);
      RA_LEFT_H: reg_rdata = REG_DW'(send_left >> 8);
      default:   reg_rdata = '0;
    endcase
  end

  assign cfg       = cfg_q;
  assign enable    = en_q;
  assign count     = cnt_q;
  assign base      = base_q;
  assign busy      = busy_q;
  assign done_flag = done_q;
  assign ovw_flag  = ovw_q;

  // R7
  ovw_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cpu_dreg_wr) |=> (!busy_q && ovw_q));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(reg_we && reg_addr == RA_STAT)) |=> done_q);

  // R9
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);

endmodule

// File: rtl/utd_fetch.sv
module utd_fetch #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic              enable,
  input  logic              hold_free,
  input  logic              cpu_dreg_wr,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        bus_pri,
  input  logic              mem_gnt,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_pri,
  output logic              take,
  output logic [CNT_W:0]    fetch_left
);

  localparam int LW = CNT_W + 1;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LW-1:0]     left_q, left_d;

  assign mem_req = run && !cpu_dreg_wr && (left_q != '0) && hold_free;
  assign take    = mem_req && mem_gnt;

  always_comb begin
    addr_d = addr_q;
    left_d = left_q;
    if (start) begin
      addr_d = base;
      left_d = LW'(count) + LW'(1);
    end else if (take) begin
      addr_d = addr_q + ADDR_W'(1);
      left_d = left_q - LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else begin
      addr_q <= addr_d;
      left_q <= left_d;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_pri    = bus_pri;
  assign fetch_left = left_q;

  // R1
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> enable);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

endmodule

// File: rtl/utd_txbuf.sv
module utd_txbuf #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic              cpu_dreg_wr,
  input  logic [CNT_W-1:0]  count,
  input  logic              take,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              hold_free,
  output logic              done_evt,
  output logic [CNT_W:0]    send_left
);

  localparam int LW = CNT_W + 1;

  logic              hold_v_q, hold_v_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic [LW-1:0]     sleft_q, sleft_d;
  logic              fire;

  assign tx_valid  = run && hold_v_q && !cpu_dreg_wr;
  assign fire      = tx_valid && tx_ready;
  assign hold_free = !hold_v_q || fire;
  assign done_evt  = fire && (sleft_q == LW'(1));

  always_comb begin
    hold_v_d = hold_v_q;
    hold_d   = hold_q;
    sleft_d  = sleft_q;
    if (take) hold_d = mem_rdata;
    if (start || !run)  hold_v_d = 1'b0;
    else if (take)      hold_v_d = 1'b1;
    else if (fire)      hold_v_d = 1'b0;
    if (start)     sleft_d = LW'(count) + LW'(1);
    else if (fire) sleft_d = sleft_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
      hold_q   <= '0;
      sleft_q  <= '0;
    end else begin
      hold_v_q <= hold_v_d;
      hold_q   <= hold_d;
      sleft_q  <= sleft_d;
    end
  end

  assign tx_data   = hold_q;
  assign send_left = sleft_q;

  // R5
  tx_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> $stable(tx_data));

  // R7
  no_send_on_cpu_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_dreg_wr |-> !tx_valid);

endmodule

// File: rtl/uart_tx_dma.sv
module uart_tx_dma
  import utd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_pri,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic              cpu_dreg_wr,
  output logic              irq,
  output logic [1:0]        irq_pri
);

  cfg_t              cfg;
  logic              enable, start, busy, done_flag, ovw_flag;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] base;
  logic [CNT_W:0]    send_left, fetch_left;
  logic              hold_free, take, done_evt;

  utd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .cpu_dreg_wr(cpu_dreg_wr), .done_evt(done_evt), .send_left(send_left),
    .cfg(cfg), .enable(enable), .count(count), .base(base),
    .start(start), .busy(busy), .done_flag(done_flag), .ovw_flag(ovw_flag)
  );

  utd_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .start(start), .run(busy), .enable(enable), .hold_free(hold_free),
    .cpu_dreg_wr(cpu_dreg_wr), .count(count), .base(base),
    .bus_pri(cfg.bus_pri), .mem_gnt(mem_gnt),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_pri(mem_pri),
    .take(take), .fetch_left(fetch_left)
  );

  utd_txbuf #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_txbuf (
    .clk(clk), .rst_n(rst_n),
    .start(start), .run(busy), .cpu_dreg_wr(cpu_dreg_wr), .count(count),
    .take(take), .mem_rdata(mem_rdata), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .hold_free(hold_free),
    .done_evt(done_evt), .send_left(send_left)
  );

  assign irq     = done_flag && cfg.irq_en;
  assign irq_pri = cfg.irq_pri;

  // R3
  send_fetch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send_left >= fetch_left) && ((send_left - fetch_left) <= (CNT_W+1)'(1)));

  // R6
  irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag);

  // R7
  ovw_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovw_flag) |-> !$rose(done_flag));

endmodule

// File: tb/tb_uart_tx_dma.sv
module tb_uart_tx_dma;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [1:0]  mem_pri;
  logic        mem_gnt = 1'b1;
  logic [7:0]  mem_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic        cpu_dreg_wr = 1'b0;
  logic        irq;
  logic [1:0]  irq_pri;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit cmp_on = 0;
  bit rnd_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [7:0] memfn(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'hA5;
  endfunction

  assign mem_rdata = memfn(mem_addr);

  uart_tx_dma dut (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_pri(mem_pri),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .cpu_dreg_wr(cpu_dreg_wr), .irq(irq), .irq_pri(irq_pri)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  bit         m_busy, m_en, m_done, m_ovw, m_irq_en;
  bit [1:0]   m_irq_pri, m_bus_pri;
  bit [7:0]   m_cnt;
  bit [15:0]  m_base, m_addr;
  int         m_fleft, m_sleft;
  logic [7:0] m_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // handshake stimulus
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready <= rnd_mode ? (lfsr[0] & lfsr[4]) : 1'b1;
    mem_gnt  <= rnd_mode ? (lfsr[7] | lfsr[2]) : 1'b1;
  end

  // model update on each active edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_en = 0; m_done = 0; m_ovw = 0; m_irq_en = 0;
      m_irq_pri = 0; m_bus_pri = 0; m_cnt = 0; m_base = 0; m_addr = 0;
      m_fleft = 0; m_sleft = 0; m_q.delete();
    end else begin
      bit tv, fire, req, take, st;
      tv   = m_busy && m_q.size() > 0 && !cpu_dreg_wr;
      fire = tv && tx_ready;
      req  = m_busy && !cpu_dreg_wr && m_fleft > 0 && (m_q.size() == 0 || fire);
      take = req && mem_gnt;
      st   = reg_we && reg_addr == 3'd1 && reg_wdata[1] && reg_wdata[0] && !m_busy;
      if (reg_we && reg_addr == 3'd2) begin
        if (!reg_wdata[0]) m_done = 0;
        if (!reg_wdata[1]) m_ovw = 0;
      end
      if (m_busy) begin
        if (cpu_dreg_wr) begin
          m_busy = 0; m_ovw = 1;
        end else begin
          if (fire) begin
            void'(m_q.pop_front());
            m_sleft--;
            if (m_sleft == 0) begin m_busy = 0; m_done = 1; end
          end
          if (take) begin
            m_q.push_back(memfn(m_addr));
            m_addr++;
            m_fleft--;
          end
          if (reg_we && reg_addr == 3'd1 && !reg_wdata[0]) m_busy = 0;
        end
        if (!m_busy) m_q.delete();
      end
      if (reg_we) begin
        case (reg_addr)
          3'd0: begin m_irq_en = reg_wdata[0]; m_irq_pri = reg_wdata[2:1]; m_bus_pri = reg_wdata[4:3]; end
          3'd1: m_en = reg_wdata[0];
          3'd3: m_cnt = reg_wdata;
          3'd4: m_base[7:0] = reg_wdata;
          3'd5: m_base[15:8] = reg_wdata;
          default: ;
        endcase
      end
      if (st) begin
        m_busy = 1; m_addr = m_base;
        m_fleft = m_cnt + 1; m_sleft = m_cnt + 1;
        m_q.delete();
      end
    end
  end

  // per-cycle comparison, three quarters into the cycle
  always @(posedge clk) begin
    #(CLK_PERIOD*3/4);
    if (cmp_on) begin
      bit tv, fire, req;
      tv   = m_busy && m_q.size() > 0 && !cpu_dreg_wr;
      fire = tv && tx_ready;
      req  = m_busy && !cpu_dreg_wr && m_fleft > 0 && (m_q.size() == 0 || fire);
      check(mem_req == req, "R3 mem_req", mem_req, req);
      if (req) begin
        check(mem_addr == m_addr, "R4 mem_addr", mem_addr, m_addr);
        check(mem_pri == m_bus_pri, "R10 mem_pri", mem_pri, m_bus_pri);
      end
      check(tx_valid == tv, "R5 tx_valid", tx_valid, tv);
      if (tv) check(tx_data == m_q[0], "R5 tx_data", tx_data, m_q[0]);
      check(irq == (m_done && m_irq_en), "R6 irq", irq, m_done && m_irq_en);
      check(irq_pri == m_irq_pri, "R10 irq_pri", irq_pri, m_irq_pri);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic cpu_hit();
    @(negedge clk);
    cpu_dreg_wr = 1'b1;
    @(negedge clk);
    cpu_dreg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && m_busy; i++) @(negedge clk);
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WD_LIMIT) begin
        fails++; tests++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, WD_LIMIT);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    // R11 reset state
    rd(3'd2, 8'h00, "R11 STAT reset");
    rd(3'd1, 8'h00, "R11 CTRL reset");
    rd(3'd0, 8'h00, "R11 CFG reset");

    // R11 readback
    wr(3'd3, 8'd3); wr(3'd4, 8'h00); wr(3'd5, 8'h01);
    rd(3'd3, 8'd3, "R11 CNT readback");
    rd(3'd5, 8'h01, "R11 BASE_H readback");

    // R1 trigger without enable
    wr(3'd1, 8'h02); idle(6);
    rd(3'd2, 8'h00, "R1 trigger while disabled");
    // R2 enable only, trigger bit 0
    wr(3'd1, 8'h01); idle(4);
    rd(3'd2, 8'h00, "R2 write of 0 to trigger");
    rd(3'd1, 8'h01, "R2 trigger reads 0");
    // R2 start, R9 busy
    wr(3'd1, 8'h03);
    rd(3'd2, 8'h04, "R9 busy after start");
    wait_done(); idle(2);
    rd(3'd2, 8'h01, "R6 done flag");
    rd(3'd6, 8'h00, "R3 LEFT after 4 bytes");
    check(irq == 1'b0, "R6 irq masked", irq, 0);

    // R10/R6 configure: bus_pri 3, irq_pri 2, irq_en 1
    wr(3'd0, 8'h1D);
    rd(3'd0, 8'h1D, "R11 CFG readback");
    check(irq == 1'b1, "R6 irq enabled", irq, 1);
    check(irq_pri == 2'd2, "R10 irq_pri", irq_pri, 2);
    // R8 writing 1 keeps, writing 0 clears
    wr(3'd2, 8'h07);
    rd(3'd2, 8'h01, "R8 write 1 keeps done");
    wr(3'd2, 8'h02);
    rd(3'd2, 8'h00, "R8 write 0 clears done");
    check(irq == 1'b0, "R8 irq cleared", irq, 0);

    // R3 single byte, random handshakes, R9 retrigger ignored
    rnd_mode = 1;
    wr(3'd3, 8'd0); wr(3'd4, 8'h7F);
    wr(3'd1, 8'h03); wr(3'd1, 8'h03);
    wait_done(); idle(2);
    rd(3'd2, 8'h01, "R3 one byte done");
    wr(3'd2, 8'h00);

    // R3/R4 256 bytes across an address carry
    wr(3'd3, 8'd255); wr(3'd4, 8'hF0); wr(3'd5, 8'h12);
    wr(3'd1, 8'h03);
    idle(40);
    wr(3'd1, 8'h03);  // R9 ignored mid-transfer
    rd(3'd2, 8'h04, "R9 still busy");
    wait_done(); idle(2);
    rd(3'd2, 8'h01, "R3 256 bytes done");
    rd(3'd6, 8'h00, "R3 LEFT_L zero");
    rd(3'd7, 8'h00, "R3 LEFT_H zero");
    wr(3'd2, 8'h00);

    // R7 abort
    wr(3'd3, 8'd20); wr(3'd4, 8'h40); wr(3'd5, 8'h00);
    wr(3'd1, 8'h03);
    idle(15);
    cpu_hit();
    rd(3'd2, 8'h02, "R7 abort status");
    rd(3'd6, 8'(m_sleft), "R7 remaining kept");
    check(m_sleft > 0 && m_sleft < 21, "R7 partial count", m_sleft, 21);
    check(irq == 1'b0, "R7 no irq on abort", irq, 0);
    wr(3'd2, 8'h01);
    rd(3'd2, 8'h00, "R8 write 0 clears ovw");
    cpu_hit();
    rd(3'd2, 8'h00, "R7 cpu write while idle");

    // R4 restart reloads base
    wr(3'd3, 8'd5);
    wr(3'd1, 8'h03);
    wait_done(); idle(2);
    rd(3'd2, 8'h01, "R4 restart completes");
    wr(3'd2, 8'h00);

    // R1 disable mid-transfer
    wr(3'd3, 8'd30);
    wr(3'd1, 8'h03);
    idle(10);
    wr(3'd1, 8'h00);
    idle(8);
    rd(3'd2, 8'h00, "R1 disable stops quietly");
    wr(3'd1, 8'h02); idle(5);
    rd(3'd2, 8'h00, "R1 trigger after disable");

    idle(4);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule